// File: doc/BRIEF.md
# Receive Timeout Length Encoder

This block turns a requested reply timeout, given in microseconds, into the pair of fields a receive timer uses: a 7-bit tick count (the length) and a 2-bit code that picks the tick size (the multiplier). A request arrives as a one-cycle strobe with a 16-bit value. One clock later the block commits the new pair to its held configuration register and raises a one-cycle done pulse. On that same cycle it also reports, in microseconds, the setting the register held just before.

The tick size grows with the request. Short requests use fine 8 us ticks. Longer ones use 16, 32 or 64 us ticks, so that the 7-bit length can still cover them. The length is always rounded up, so the timer never expires before the requested time. Anything too long for the coarsest tick is clamped to the largest length. A request of zero selects a fixed default setting.

Top module: `rxto_encoder`

## Requirements
- R1: While reset is high and on the first cycle after it, the register holds length 69 with multiplier code 0, done is low and the previous-value output is 0.
- R2: A request of 0 us commits length 69 with multiplier code 0.
- R3: A nonzero request up to 1016 us selects code 0 (8 us tick). Above that and up to 2032 us it selects code 1 (16 us tick). Above that and up to 4064 us it selects code 2 (32 us tick). Anything larger selects code 3 (64 us tick).
- R4: The committed length is the request divided by the tick of the selected code, rounded up whenever the division leaves a remainder.
- R5: A length that would exceed 127 is committed as 127.
- R6: On each done pulse, the previous-value output equals the length held before the request, multiplied by the tick (8 << code) of the code held before it. The first request after reset therefore reports 552.
- R7: Done is high for exactly the one cycle after each accepted strobe. The length and the code change only on a cycle where done is high, and both change together.
- R8: Strobes on consecutive cycles are each accepted. Each one commits its own setting and reports the setting left by the one before it.
- R9: Between done pulses, the previous-value output keeps the value it took at the last pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_us | input | 16 | Requested timeout in microseconds |
| cfg_len | output | 7 | Held length field (ticks) |
| cfg_mul | output | 2 | Held multiplier code (tick = 8 << code us) |
| prev_us | output | 13 | Timeout that was held before the last request, in us |
| done | output | 1 | One-cycle pulse when a new setting is committed |

## Verification
The bench builds the block with its default parameters: a 16-bit request, a 1016 us band and 7-bit lengths. With these values every band edge (1016/1017, 2032/2033, 4064/4065) lies within the request width. So does the start of clamping at 8129 and the 16-bit ceiling of 65535, where the rounding add would carry out of the request width. Requests are also sent back to back and with idle gaps, so every pairing of old and new setting shows up in the reported previous value.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    // Widths and constants of the timeout encoding.
    localparam int TO_IN_W      = 16;   // request width, microseconds
    localparam int TO_LEN_W     = 7;    // length field width
    localparam int TO_MUL_W     = 2;    // multiplier code width
    localparam int TO_BANDS     = 1 << TO_MUL_W;
    localparam int TO_BASE_SH   = 3;    // finest tick is 1 << 3 us
    localparam int TO_BAND_US   = 1016; // upper edge of the finest band
    localparam int TO_DEF_LEN   = 69;   // length used for a zero request
    localparam int TO_MAX_LEN   = (1 << TO_LEN_W) - 1;
    localparam int TO_PREV_W    = TO_LEN_W + TO_BASE_SH + TO_BANDS - 1;

    typedef enum logic [TO_MUL_W-1:0] {
        BAND_FINE = 2'd0,
        BAND_MID  = 2'd1,
        BAND_WIDE = 2'd2,
        BAND_MAX  = 2'd3
    } band_e;

    typedef struct packed {
        logic [TO_LEN_W-1:0] len;
        band_e               mul;
    } to_cfg_t;

    function automatic to_cfg_t default_cfg();
        to_cfg_t c;
        c.len = TO_LEN_W'(TO_DEF_LEN);
        c.mul = BAND_FINE;
        return c;
    endfunction

endpackage

// File: rtl/rxto_band_select.sv
module rxto_band_select
    import rxto_pkg::*;
#(
    parameter int IN_W    = TO_IN_W,
    parameter int BAND_US = TO_BAND_US
) (
    input  logic [IN_W-1:0] req_us,
    output band_e           band
);
    // Thermometer of "above this band's upper edge"; edges double per band.
    localparam int EDGES = TO_BANDS - 1;

    logic [EDGES-1:0] above;

    for (genvar k = 0; k < EDGES; k++) begin : g_edge
        localparam logic [IN_W:0] EDGE_US = (IN_W+1)'(BAND_US << k);
        assign above[k] = ({1'b0, req_us} > EDGE_US);
    end

    always_comb begin
        logic [TO_MUL_W-1:0] idx;
        idx = '0;
        for (int k = 0; k < EDGES; k++) begin
            idx = idx + TO_MUL_W'(above[k]);
        end
        band = band_e'(idx);
    end
endmodule

// File: rtl/rxto_len_calc.sv
module rxto_len_calc
    import rxto_pkg::*;
#(
    parameter int IN_W    = TO_IN_W,
    parameter int DEF_LEN = TO_DEF_LEN
) (
    input  logic [IN_W-1:0] req_us,
    input  band_e           band,
    output to_cfg_t         cfg
);
    localparam logic [IN_W:0] MAX_WIDE = (IN_W+1)'(TO_MAX_LEN);

    // One rounded-up quotient per band; the divisor is a power of two.
    logic [IN_W:0] quot [TO_BANDS];

    for (genvar b = 0; b < TO_BANDS; b++) begin : g_band
        localparam int            SH  = TO_BASE_SH + b;
        localparam logic [IN_W:0] RND = (IN_W+1)'((1 << SH) - 1);
        logic [IN_W:0] biased;
        assign biased  = {1'b0, req_us} + RND;
        assign quot[b] = biased >> SH;
    end

    always_comb begin
        logic [IN_W:0] q;
        q = quot[band];
        if (req_us == '0) begin
            cfg.len = TO_LEN_W'(DEF_LEN);
            cfg.mul = BAND_FINE;
        end else begin
            cfg.mul = band;
            if (q > MAX_WIDE) begin
                cfg.len = TO_LEN_W'(TO_MAX_LEN);
            end else begin
                cfg.len = q[TO_LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rxto_prev_decode.sv
module rxto_prev_decode
    import rxto_pkg::*;
#(
    parameter int PREV_W = TO_PREV_W
) (
    input  to_cfg_t           cfg,
    output logic [PREV_W-1:0] span_us
);
    // Microseconds = length * (1 << (base shift + code)).
    always_comb begin
        span_us = PREV_W'(cfg.len) << (TO_BASE_SH + int'(cfg.mul));
    end
endmodule

// File: rtl/rxto_encoder.sv
module rxto_encoder
    import rxto_pkg::*;
#(
    parameter int IN_W    = TO_IN_W,
    parameter int BAND_US = TO_BAND_US,
    parameter int DEF_LEN = TO_DEF_LEN,
    parameter int PREV_W  = TO_PREV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [IN_W-1:0]     req_us,
    output logic [TO_LEN_W-1:0] cfg_len,
    output logic [TO_MUL_W-1:0] cfg_mul,
    output logic [PREV_W-1:0]   prev_us,
    output logic                done
);
    band_e             band;
    to_cfg_t           cfg_next;
    to_cfg_t           cfg_q;
    logic [PREV_W-1:0] held_us;
    logic [PREV_W-1:0] prev_q;
    logic              done_q;

    rxto_band_select #(
        .IN_W    (IN_W),
        .BAND_US (BAND_US)
    ) u_band (
        .req_us (req_us),
        .band   (band)
    );

    rxto_len_calc #(
        .IN_W    (IN_W),
        .DEF_LEN (DEF_LEN)
    ) u_len (
        .req_us (req_us),
        .band   (band),
        .cfg    (cfg_next)
    );

    rxto_prev_decode #(
        .PREV_W (PREV_W)
    ) u_prev (
        .cfg     (cfg_q),
        .span_us (held_us)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.len <= TO_LEN_W'(DEF_LEN);
            cfg_q.mul <= BAND_FINE;
            prev_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= req_valid;
            if (req_valid) begin
                cfg_q  <= cfg_next;
                prev_q <= held_us;
            end
        end
    end

    assign cfg_len = cfg_q.len;
    assign cfg_mul = cfg_q.mul;
    assign prev_us = prev_q;
    assign done    = done_q;
endmodule

// File: rtl/rxto_encoder_chk.sv
module rxto_encoder_chk
    import rxto_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [TO_IN_W-1:0]   req_us,
    input logic [TO_LEN_W-1:0]  cfg_len,
    input logic [TO_MUL_W-1:0]  cfg_mul,
    input logic [TO_PREV_W-1:0] prev_us,
    input logic                 done
);
    // armed goes high once a full cycle out of reset has been sampled.
    logic                armed;
    logic [TO_LEN_W-1:0] len_d;
    logic [TO_MUL_W-1:0] mul_d;
    logic                zero_d;

    always_ff @(posedge clk) begin
        armed  <= !rst;
        len_d  <= cfg_len;
        mul_d  <= cfg_mul;
        zero_d <= req_valid && (req_us == '0);
    end

    // R7: done follows an accepted strobe by exactly one cycle
    assert_done_after_valid_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);
    assert_done_pulse_only_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done);

    // R7: the setting only moves with done
    assert_cfg_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && !done) |-> ($stable(cfg_len) && $stable(cfg_mul)));

    // R9: the previous value is held between pulses
    assert_prev_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !done) |-> $stable(prev_us));

    // R5 and R4: a committed length is never 0 and never above the clamp
    assert_len_bounds_R5: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cfg_len != '0 && 32'(cfg_len) <= TO_MAX_LEN));

    // R2: a zero request yields the default setting
    assert_zero_default_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && done && zero_d) |-> (32'(cfg_len) == TO_DEF_LEN && cfg_mul == '0));

    // R6: reported value matches the setting held before the pulse
    assert_prev_value_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && done) |->
            (prev_us == (TO_PREV_W'(len_d) << (TO_BASE_SH + int'(mul_d)))));
endmodule

bind rxto_encoder rxto_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_us    (req_us),
    .cfg_len   (cfg_len),
    .cfg_mul   (cfg_mul),
    .prev_us   (prev_us),
    .done      (done)
);

// File: tb/rxto_encoder_bench.sv
`timescale 1ns/1ps
module rxto_encoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_us = '0;
    logic [6:0]  cfg_len;
    logic [1:0]  cfg_mul;
    logic [12:0] prev_us;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    rxto_encoder u_rxto_encoder (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_us    (req_us),
        .cfg_len   (cfg_len),
        .cfg_mul   (cfg_mul),
        .prev_us   (prev_us),
        .done      (done)
    );

    // Behavioural reference model, updated on every rising edge.
    int m_len = 69, m_mul = 0, m_prev = 0, m_done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_len = 69; m_mul = 0; m_prev = 0; m_done = 0;
        end else if (req_valid) begin
            int v, step, q;
            v = int'(req_us);
            m_prev = m_len * (8 * (2 ** m_mul));
            if (v == 0) begin
                m_mul = 0; q = 69;
            end else begin
                if (v <= 1016)      m_mul = 0;
                else if (v <= 2032) m_mul = 1;
                else if (v <= 4064) m_mul = 2;
                else                m_mul = 3;
                step = 8 * (2 ** m_mul);
                q = v / step;
                if (v % step != 0) q = q + 1;
                if (q > 127) q = 127;
            end
            m_len = q;
            m_done = 1;
        end else begin
            m_done = 0;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if (int'(cfg_len) != m_len || int'(cfg_mul) != m_mul ||
                int'(prev_us) != m_prev || int'(done) != m_done) begin
                n_errors++;
                $display("FAIL %s model: len=%0d mul=%0d prev=%0d done=%0d expected len=%0d mul=%0d prev=%0d done=%0d",
                         tag, cfg_len, cfg_mul, prev_us, done, m_len, m_mul, m_prev, m_done);
            end
        end
    end

    task automatic check(string t, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // Strobe one request; returns at the negedge where the result is visible.
    task automatic send(int v);
        req_us    = 16'(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_check(string t, int v, int len, int mul);
        tag = t;
        send(v);
        check({t, " done"}, int'(done), 1);
        check({t, " len"}, int'(cfg_len), len);
        check({t, " mul"}, int'(cfg_mul), mul);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 len", int'(cfg_len), 69);
        check("R1 mul", int'(cfg_mul), 0);
        check("R1 done", int'(done), 0);
        check("R1 prev", int'(prev_us), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 len after release", int'(cfg_len), 69);
        check("R1 done after release", int'(done), 0);

        // R6: first report is the default setting
        send_check("R3", 1, 1, 0);
        check("R6 first prev", int'(prev_us), 552);
        // R9: held across idle cycles
        tag = "R9";
        repeat (4) @(negedge clk);
        check("R9 prev held", int'(prev_us), 552);
        check("R9 done low", int'(done), 0);
        check("R7 len stable", int'(cfg_len), 1);

        send_check("R4", 8, 1, 0);
        check("R6 prev", int'(prev_us), 8);
        send_check("R4", 9, 2, 0);
        send_check("R5", 1016, 127, 0);
        send_check("R3", 1017, 64, 1);
        check("R6 prev fine", int'(prev_us), 1016);
        send_check("R5", 2032, 127, 1);
        send_check("R3", 2033, 64, 2);
        check("R6 prev mid", int'(prev_us), 2032);
        send_check("R5", 4064, 127, 2);
        send_check("R3", 4065, 64, 3);
        check("R6 prev wide", int'(prev_us), 4064);
        send_check("R5", 8128, 127, 3);
        send_check("R5", 8129, 127, 3);
        check("R6 prev max", int'(prev_us), 8128);
        send_check("R5", 65535, 127, 3);
        send_check("R2", 0, 69, 0);
        check("R6 prev clamp", int'(prev_us), 8128);
        send_check("R4", 100, 13, 0);
        check("R6 prev default", int'(prev_us), 552);

        // R8: back-to-back strobes
        send_check("R8", 3000, 94, 2);
        send_check("R8", 50, 7, 0);
        check("R8 prev of previous", int'(prev_us), 3008);
        send_check("R8", 1500, 94, 1);
        check("R8 prev chain", int'(prev_us), 56);
        @(negedge clk);
        check("R7 single pulse", int'(done), 0);

        // Random mix, checked against the model every cycle.
        tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            int v;
            v = ($urandom % 4 == 0) ? int'($urandom % 16'hFFFF) : int'($urandom % 9000);
            if ($urandom % 3 == 0) begin
                @(negedge clk);
            end else begin
                send(v);
            end
        end
        @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule